// File: doc/BRIEF.md
# Time-Interval Gate Controller

This block runs the main counting gate for a time-interval measurement. After a measurement reset and with the inhibit input high, it arms. The next rising edge on the start channel opens the gate. Opening the gate also loads a holdoff counter. While that counter runs, edges on the stop channel are ignored. Once it expires, the next rising stop edge closes the gate. The gate then stays closed until another measurement reset arrives and inhibit is high again.

While the gate is open, the block produces a count enable for the external accumulator. The enable follows one of two sources, chosen by a resolution select input:
- the reference clock itself, giving one enable per cycle;
- one of several decade tick strobes from an external time base.

The block also has three further outputs:
- monitor copies of the gate state and of the holdoff window;
- a one-cycle pulse on each rising edge of the measurement-done input;
- a status code that shows the internal state.

Top module: `tig_gate_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it, status reads 0 (idle), and gate_out, delay_out, count_en and max_pulse are all 0.
- R2: From idle (0), the cycle after inhibit is sampled high, status becomes armed (1). In armed, inhibit sampled low returns the block to idle. Start edges have no effect while idle.
- R3: start_in passes through a two-flop synchronizer. A rising start edge seen in armed moves status to open (2), three clock edges after start_in rises. In open, gate_out and delay_out are both 1.
- R4: The holdoff length is L = max(holdoff_cfg, 2). delay_out stays 1 for exactly L cycles after the gate opens. Then status becomes holdoff-expired (3), delay_out drops to 0 and gate_out stays 1.
- R5: stop_in has the same synchronizer. Stop edges while open (2) are ignored. A rising stop edge in expired (3) moves status to closed (4), three clock edges after stop_in rises, and gate_out drops to 0.
- R6: In closed (4), neither start edges nor inhibit transitions reopen the gate. Only a meas_reset followed by inhibit high re-arms the block.
- R7: meas_reset sampled high sends the block to idle (0) on the next cycle from any state, and it overrides every other input.
- R8: count_en is 0 whenever gate_out is 0. When gate_out is 1, count_en depends on res_sel:
  - res_sel = 0: count_en is 1 every cycle.
  - res_sel = k with 1 <= k <= 4: count_en equals tb_tick[k-1].
  - res_sel above 4: count_en is 0.
- R9: max_pulse is 1 for exactly one cycle after each rising edge of meas_done, visible one clock edge after the edge is sampled, however long meas_done stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; holdoff is counted in its periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_reset | input | 1 | Synchronous measurement reset, returns to idle |
| inhibit | input | 1 | Arming permit, level sensitive |
| start_in | input | 1 | Start channel, asynchronous |
| stop_in | input | 1 | Stop channel, asynchronous |
| holdoff_cfg | input | 16 | Holdoff length in clock periods, minimum 2 |
| res_sel | input | 3 | Count source select: 0 = reference clock, k = tb_tick[k-1] |
| tb_tick | input | 4 | Decade time-base tick strobes |
| meas_done | input | 1 | Measurement-done level; its rising edge makes max_pulse |
| gate_out | output | 1 | Gate open monitor |
| delay_out | output | 1 | Holdoff window monitor |
| count_en | output | 1 | Count enable for the accumulator |
| max_pulse | output | 1 | One-cycle end-of-measurement pulse |
| status | output | 3 | 0 idle, 1 armed, 2 open, 3 expired, 4 closed |

## Verification
On every cycle, the assertions check the following:
- a stop event never closes the gate during holdoff;
- the holdoff done strobe always moves the block to expired;
- the closed state holds until a measurement reset;
- a measurement reset always lands in idle;
- count enables never appear outside the gate;
- max_pulse never lasts two cycles.

Only the bench scenarios can show the quantities that need a stimulus history:
- the exact holdoff length for clamped and unclamped settings;
- the three-edge latency from the start and stop pins;
- the mapping from each resolution select value to its tick.

// File: rtl/tig_pkg.sv
package tig_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARMED   = 3'd1,
    ST_OPEN    = 3'd2,
    ST_EXPIRED = 3'd3,
    ST_CLOSED  = 3'd4
  } tig_state_e;

  // Holdoff length actually loaded: the setting, raised to the floor.
  function automatic int unsigned clamp_holdoff(input int unsigned cfg,
                                                input int unsigned floor_len);
    return (cfg < floor_len) ? floor_len : cfg;
  endfunction

endpackage

// File: rtl/tig_edge_sync.sv
module tig_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/tig_holdoff.sv
module tig_holdoff #(
  parameter int W       = 16,
  parameter int MIN_LEN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] cfg,
  input  logic         run,
  output logic         done
);
  localparam logic [W-1:0] FLOOR = W'(MIN_LEN);

  logic [W-1:0] cnt;

  function automatic logic [W-1:0] load_value(input logic [W-1:0] c);
    return (c < FLOOR) ? FLOOR : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_value(cfg);
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == W'(1));
endmodule

// File: rtl/tig_clk_sel.sv
module tig_clk_sel #(
  parameter int NDIV  = 4,
  parameter int SEL_W = $clog2(NDIV + 1)
) (
  input  logic [SEL_W-1:0] res_sel,
  input  logic [NDIV-1:0]  tb_tick,
  input  logic             gate,
  output logic             count_en
);
  localparam int NSRC = 1 << SEL_W;

  logic [NSRC-1:0] src;

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_src
      if (k == 0) begin : g_raw
        assign src[k] = 1'b1;
      end else if (k <= NDIV) begin : g_div
        assign src[k] = tb_tick[k-1];
      end else begin : g_none
        assign src[k] = 1'b0;
      end
    end
  endgenerate

  assign count_en = gate & src[res_sel];
endmodule

// File: rtl/tig_gate_ctrl.sv
module tig_gate_ctrl
  import tig_pkg::*;
#(
  parameter int HO_W    = 16,
  parameter int HO_MIN  = 2,
  parameter int NDIV    = 4,
  parameter int SYNC_N  = 2,
  localparam int SEL_W  = $clog2(NDIV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_reset,
  input  logic             inhibit,
  input  logic             start_in,
  input  logic             stop_in,
  input  logic [HO_W-1:0]  holdoff_cfg,
  input  logic [SEL_W-1:0] res_sel,
  input  logic [NDIV-1:0]  tb_tick,
  input  logic             meas_done,
  output logic             gate_out,
  output logic             delay_out,
  output logic             count_en,
  output logic             max_pulse,
  output logic [2:0]       status
);
  tig_state_e state_q, state_d;

  // Named internal events, also observed by the checker.
  logic start_evt;
  logic stop_evt;
  logic ho_load;
  logic ho_run;
  logic ho_done;
  logic done_last;

  tig_edge_sync #(.STAGES(SYNC_N)) u_start_sync (
    .clk(clk), .rst_n(rst_n), .d(start_in), .rise(start_evt)
  );

  tig_edge_sync #(.STAGES(SYNC_N)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .d(stop_in), .rise(stop_evt)
  );

  assign ho_load = (state_q == ST_ARMED) && inhibit && start_evt && !meas_reset;
  assign ho_run  = (state_q == ST_OPEN);

  tig_holdoff #(.W(HO_W), .MIN_LEN(HO_MIN)) u_holdoff (
    .clk(clk), .rst_n(rst_n), .load(ho_load), .cfg(holdoff_cfg),
    .run(ho_run), .done(ho_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (inhibit) state_d = ST_ARMED;
      ST_ARMED: begin
        if (!inhibit)       state_d = ST_IDLE;
        else if (start_evt) state_d = ST_OPEN;
      end
      ST_OPEN:    if (ho_done)  state_d = ST_EXPIRED;
      ST_EXPIRED: if (stop_evt) state_d = ST_CLOSED;
      ST_CLOSED:  state_d = ST_CLOSED;
      default:    state_d = ST_IDLE;
    endcase
    if (meas_reset) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_last <= 1'b0;
      max_pulse <= 1'b0;
    end else begin
      done_last <= meas_done;
      max_pulse <= meas_done & ~done_last;
    end
  end

  assign gate_out  = (state_q == ST_OPEN) || (state_q == ST_EXPIRED);
  assign delay_out = (state_q == ST_OPEN);
  assign status    = state_q;

  tig_clk_sel #(.NDIV(NDIV)) u_clk_sel (
    .res_sel(res_sel), .tb_tick(tb_tick), .gate(gate_out), .count_en(count_en)
  );
endmodule

// File: rtl/tig_gate_chk.sv
module tig_gate_chk
  import tig_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       meas_reset,
  input logic [2:0] status,
  input logic       gate_out,
  input logic       count_en,
  input logic       max_pulse,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       ho_done
);
  AST_NO_OPEN_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_ARMED && !start_evt) |=> status != ST_OPEN); // R3
  AST_OPEN_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_out) |-> $past(status) == ST_ARMED); // R3
  AST_EXPIRE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_OPEN && ho_done && !meas_reset) |=> status == ST_EXPIRED); // R4
  AST_NO_EARLY_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_OPEN && !meas_reset) |=> status inside {ST_OPEN, ST_EXPIRED}); // R5
  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_EXPIRED && stop_evt && !meas_reset) |=> status == ST_CLOSED); // R5
  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_CLOSED && !meas_reset) |=> status == ST_CLOSED); // R6
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_reset |=> status == ST_IDLE); // R7
  AST_COUNT_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> gate_out); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    max_pulse |=> !max_pulse); // R9
endmodule

bind tig_gate_ctrl tig_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .meas_reset(meas_reset), .status(status),
  .gate_out(gate_out), .count_en(count_en), .max_pulse(max_pulse),
  .start_evt(start_evt), .stop_evt(stop_evt), .ho_done(ho_done)
);

// File: tb/sim_tig_gate_ctrl.sv
module sim_tig_gate_ctrl;
  localparam int NDIV  = 4;
  localparam int SEL_W = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, meas_reset = 1'b0, inhibit = 1'b0;
  logic start_in = 1'b0, stop_in = 1'b0, meas_done = 1'b0;
  logic [15:0] holdoff_cfg = '0;
  logic [SEL_W-1:0] res_sel = '0;
  logic [NDIV-1:0] tb_tick = '0;
  logic gate_out, delay_out, count_en, max_pulse;
  logic [2:0] status;

  int n_chk = 0, n_fail = 0;

  tig_gate_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .meas_reset(meas_reset), .inhibit(inhibit),
    .start_in(start_in), .stop_in(stop_in), .holdoff_cfg(holdoff_cfg),
    .res_sel(res_sel), .tb_tick(tb_tick), .meas_done(meas_done),
    .gate_out(gate_out), .delay_out(delay_out), .count_en(count_en),
    .max_pulse(max_pulse), .status(status)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Return to armed with inhibit high.
  task automatic rearm();
    meas_reset = 1'b1; inhibit = 1'b1; cyc(1);
    meas_reset = 1'b0; cyc(1);
  endtask

  // From armed: start edge opens on the third edge (R3).
  task automatic open_gate(input int cfg);
    holdoff_cfg = 16'(cfg);
    start_in = 1'b1; cyc(2);
    chk("R3", "status before open", int'(status), 1);
    cyc(1);
    chk("R3", "status open", int'(status), 2);
    chk("R3", "gate_out open", int'(gate_out), 1);
    chk("R3", "delay_out open", int'(delay_out), 1);
    start_in = 1'b0;
  endtask

  task automatic wait_expired();
    int guard = 0;
    while (status != 3'd3 && guard < 70000) begin guard++; cyc(1); end
  endtask

  task automatic close_gate();
    stop_in = 1'b1; cyc(2);
    chk("R5", "status before close", int'(status), 3);
    cyc(1);
    chk("R5", "status closed", int'(status), 4);
    chk("R5", "gate_out closed", int'(gate_out), 0);
    stop_in = 1'b0; cyc(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cyc(3);
    chk("R1", "status", int'(status), 0);
    chk("R1", "gate_out", int'(gate_out), 0);
    chk("R1", "delay_out", int'(delay_out), 0);
    chk("R1", "count_en", int'(count_en), 0);
    chk("R1", "max_pulse", int'(max_pulse), 0);
    rst_n = 1'b1; cyc(1);
    chk("R1", "status after release", int'(status), 0);
  endtask

  task automatic t_arm();
    start_in = 1'b1; cyc(4); start_in = 1'b0; cyc(4);
    chk("R2", "start ignored in idle", int'(status), 0);
    inhibit = 1'b1; cyc(1);
    chk("R2", "armed", int'(status), 1);
    inhibit = 1'b0; cyc(1);
    chk("R2", "disarm", int'(status), 0);
  endtask

  task automatic t_holdoff(input int cfg);
    int exp_len = (cfg < 2) ? 2 : cfg;
    int n = 1;
    rearm();
    open_gate(cfg);
    cyc(1);
    while (delay_out === 1'b1 && n < 70000) begin n++; cyc(1); end
    chk("R4", $sformatf("holdoff length cfg=%0d", cfg), n, exp_len);
    chk("R4", "expired status", int'(status), 3);
    chk("R4", "gate held after holdoff", int'(gate_out), 1);
    close_gate();
  endtask

  task automatic t_stop_ignored();
    rearm();
    open_gate(40);
    stop_in = 1'b1; cyc(3); stop_in = 1'b0; cyc(3);
    chk("R5", "stop ignored in holdoff", int'(status), 2);
    wait_expired();
    chk("R5", "gate still open after holdoff", int'(gate_out), 1);
    close_gate();
  endtask

  task automatic t_sticky();
    start_in = 1'b1; cyc(4); start_in = 1'b0; cyc(4);
    chk("R6", "start ignored when closed", int'(status), 4);
    chk("R6", "gate stays low", int'(gate_out), 0);
    inhibit = 1'b0; cyc(2); inhibit = 1'b1; cyc(2);
    chk("R6", "inhibit cycle ignored", int'(status), 4);
    meas_reset = 1'b1; cyc(1); meas_reset = 1'b0;
    chk("R7", "idle after reset from closed", int'(status), 0);
    cyc(1);
    chk("R6", "re-armed", int'(status), 1);
  endtask

  task automatic t_meas_reset();
    rearm();
    open_gate(100);
    meas_reset = 1'b1; start_in = 1'b1; cyc(1);
    chk("R7", "idle from open", int'(status), 0);
    chk("R7", "gate low", int'(gate_out), 0);
    meas_reset = 1'b0; start_in = 1'b0; cyc(4);
    rearm();
    open_gate(2);
    wait_expired();
    meas_reset = 1'b1; stop_in = 1'b1; cyc(1);
    chk("R7", "idle from expired", int'(status), 0);
    meas_reset = 1'b0; stop_in = 1'b0; cyc(4);
  endtask

  task automatic t_count_sel();
    logic [NDIV-1:0] pats [2];
    pats[0] = 4'b0101; pats[1] = 4'b1010;
    rearm();
    open_gate(2);
    wait_expired();
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 8; s++) begin
        int exp_v;
        res_sel = 3'(s); tb_tick = pats[p];
        exp_v = (s == 0) ? 1 : ((s <= NDIV) ? int'(pats[p][s-1]) : 0);
        #1;
        chk("R8", $sformatf("count_en sel=%0d tick=%b", s, pats[p]), int'(count_en), exp_v);
        cyc(1);
      end
    end
    close_gate();
    res_sel = '0; tb_tick = '1; #1;
    chk("R8", "no count when closed", int'(count_en), 0);
    tb_tick = '0;
  endtask

  task automatic t_pulse();
    int hits = 0;
    meas_done = 1'b1; cyc(1);
    chk("R9", "pulse on rise", int'(max_pulse), 1);
    for (int i = 0; i < 5; i++) begin cyc(1); hits += int'(max_pulse); end
    chk("R9", "single pulse while high", hits, 0);
    meas_done = 1'b0; cyc(2);
    chk("R9", "no pulse on fall", int'(max_pulse), 0);
    meas_done = 1'b1; cyc(1);
    chk("R9", "second rise pulses", int'(max_pulse), 1);
    meas_done = 1'b0; cyc(2);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(1);
    t_reset();
    t_arm();
    t_holdoff(0);
    t_holdoff(1);
    t_holdoff(2);
    t_holdoff(25);
    t_holdoff(300);
    t_stop_ignored();
    t_sticky();
    t_meas_reset();
    t_count_sel();
    t_pulse();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule